// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a virtual address that missed in the translation cache. It reads a two-level page table held in memory. The 32-bit virtual address has three fields. Bits 31:22 index the outer table, bits 21:12 index the inner table and bits 11:0 are the page offset. Each table entry is 4 bytes wide, so every table has 1024 entries and fills one 4 KB frame.

A walk begins when the translation cache offers a request while the walker is idle. The walker reads the outer entry at the table base. If that entry is valid, its frame number locates the inner table, and the walker reads the selected inner entry. When the inner entry is valid, the walker returns the physical address and the entry's permission and usage flags so that the cache can refill. If the entry at either level is invalid, the walker instead returns a fault that names the level, the virtual address and the process ID.

Only one memory read is ever outstanding. The walker never writes to memory, so the referenced and modified bits are passed to the requester unchanged.

Top module: `pt_walker2`

## Requirements
- R1: The first read of a walk is issued at address `table_base + 4 * vaddr[31:22]`.
- R2: When the outer entry is valid, the second read is issued at `{outer_entry[31:12], 12'h000} + 4 * vaddr[21:12]`.
- R3: When both entries are valid, the response has `rsp_fault = 0` and `rsp_paddr = {inner_entry[31:12], vaddr[11:0]}`.
- R4: On a successful walk, `rsp_writable`, `rsp_referenced` and `rsp_modified` are copies of bits 1, 5 and 6 of the inner entry. The valid flag is bit 0 of an entry.
- R5: An outer entry with bit 0 clear ends the walk with `rsp_fault = 1` and `rsp_fault_inner = 0`, and no second read is issued.
- R6: An inner entry with bit 0 clear ends the walk with `rsp_fault = 1` and `rsp_fault_inner = 1`.
- R7: Every response returns the virtual address and the process ID of the request that started the walk, on `rsp_vaddr` and `rsp_pid`.
- R8: `req_ready` is high only while the walker is idle. A request offered during a walk is not taken and does not alter the walk in progress.
- R9: At most one memory read is outstanding. While `mem_req_valid` is high without `mem_req_ready`, the request and its address stay unchanged.
- R10: Each walk produces exactly one `rsp_valid` pulse, one cycle long, and the walker is idle in the following cycle.
- R11: A memory response that arrives while no read is pending is ignored.
- R12: Synchronous reset, including reset in the middle of a walk, leaves `req_ready = 1`, `mem_req_valid = 0` and `rsp_valid = 0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle; the request is taken this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_pid | input | 8 | Process ID of the request |
| table_base | input | 32 | Byte address of the outer table, sampled when a request is taken |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry read from memory |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_fault | output | 1 | Walk ended on an invalid entry |
| rsp_fault_inner | output | 1 | Fault level: 0 outer, 1 inner |
| rsp_paddr | output | 32 | Translated physical address (zero on a fault) |
| rsp_writable | output | 1 | Write permission of the page |
| rsp_referenced | output | 1 | Referenced flag of the page |
| rsp_modified | output | 1 | Modified flag of the page |
| rsp_vaddr | output | 32 | Virtual address of the finished walk |
| rsp_pid | output | 8 | Process ID of the finished walk |

## Verification
The embedded assertions check the properties that hold on every cycle. These are the single outstanding read, the stability of a stalled read, the one-cycle response pulse followed by a return to idle, the read count of one for an outer fault and two otherwise, and the offset copied into the physical address. Some behaviour depends on what the table in memory contains, and only the bench's scenarios can show it. This covers the exact entry addresses for indices at both ends of the range, the frame and flag values taken from particular entries, and faults at each level. The scenarios also cover requests and stray memory responses that arrive while the walker is busy or idle, and a reset in the middle of a walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // Walk sequencing states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_OUTER,
    ST_WT_OUTER,
    ST_RD_INNER,
    ST_WT_INNER,
    ST_DONE,
    ST_FAULT
  } walk_state_e;

  // Flag bit positions inside a table entry
  localparam int unsigned FLAG_VALID_BIT = 0;
  localparam int unsigned FLAG_WRITE_BIT = 1;
  localparam int unsigned FLAG_REF_BIT   = 5;
  localparam int unsigned FLAG_MOD_BIT   = 6;

  typedef struct packed {
    logic valid;
    logic writable;
    logic referenced;
    logic modified;
  } pte_flags_t;

endpackage

// File: rtl/ptw_addr_calc.sv
module ptw_addr_calc #(
  parameter int IDX_W     = 10,
  parameter int OFFS_W    = 12,
  parameter int ENT_BYTES = 4,
  localparam int VA_W     = 2 * IDX_W + OFFS_W,
  localparam int FRAME_W  = VA_W - OFFS_W
) (
  input  logic [VA_W-1:0]    vaddr,
  input  logic [VA_W-1:0]    table_base,
  input  logic [FRAME_W-1:0] outer_frame,
  output logic [VA_W-1:0]    outer_addr,
  output logic [VA_W-1:0]    inner_addr
);
  localparam int ENT_SH = $clog2(ENT_BYTES);

  logic [IDX_W-1:0] hi_idx;
  logic [IDX_W-1:0] lo_idx;
  logic [VA_W-1:0]  hi_off;
  logic [VA_W-1:0]  lo_off;

  always_comb begin
    hi_idx     = vaddr[VA_W-1 -: IDX_W];
    lo_idx     = vaddr[OFFS_W +: IDX_W];
    hi_off     = VA_W'(hi_idx) << ENT_SH;
    lo_off     = VA_W'(lo_idx) << ENT_SH;
    outer_addr = table_base + hi_off;
    inner_addr = {outer_frame, {OFFS_W{1'b0}}} + lo_off;
  end

endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
  import ptw_pkg::*;
#(
  parameter int ENT_W    = 32,
  parameter int OFFS_W   = 12,
  localparam int FRAME_W = ENT_W - OFFS_W
) (
  input  logic [ENT_W-1:0]   entry,
  output logic [FRAME_W-1:0] frame,
  output pte_flags_t         flags
);
  always_comb begin
    frame            = entry[OFFS_W +: FRAME_W];
    flags.valid      = entry[FLAG_VALID_BIT];
    flags.writable   = entry[FLAG_WRITE_BIT];
    flags.referenced = entry[FLAG_REF_BIT];
    flags.modified   = entry[FLAG_MOD_BIT];
  end

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        mem_req_ready,
  input  logic        mem_rsp_valid,
  input  logic        entry_valid,
  output walk_state_e state,
  output logic        accept,
  output logic        outer_ok,
  output logic        outer_bad,
  output logic        inner_ok,
  output logic        inner_bad
);
  walk_state_e nxt;

  always_comb begin
    nxt       = state;
    accept    = 1'b0;
    outer_ok  = 1'b0;
    outer_bad = 1'b0;
    inner_ok  = 1'b0;
    inner_bad = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          nxt    = ST_RD_OUTER;
        end
      end
      ST_RD_OUTER: if (mem_req_ready) nxt = ST_WT_OUTER;
      ST_WT_OUTER: begin
        if (mem_rsp_valid) begin
          outer_ok  = entry_valid;
          outer_bad = !entry_valid;
          nxt       = entry_valid ? ST_RD_INNER : ST_FAULT;
        end
      end
      ST_RD_INNER: if (mem_req_ready) nxt = ST_WT_INNER;
      ST_WT_INNER: begin
        if (mem_rsp_valid) begin
          inner_ok  = entry_valid;
          inner_bad = !entry_valid;
          nxt       = entry_valid ? ST_DONE : ST_FAULT;
        end
      end
      ST_DONE:  nxt = ST_IDLE;
      ST_FAULT: nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  // R11: while idle and no request arrives, memory activity cannot start a walk
  a_r11_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !req_valid) |=> state == ST_IDLE);

  // R10: a result state lasts exactly one cycle
  a_r10_result_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE || state == ST_FAULT) |=> state == ST_IDLE);

endmodule

// File: rtl/pt_walker2.sv
module pt_walker2
  import ptw_pkg::*;
#(
  parameter int IDX_W     = 10,
  parameter int OFFS_W    = 12,
  parameter int ENT_BYTES = 4,
  parameter int PID_W     = 8,
  localparam int VA_W     = 2 * IDX_W + OFFS_W,
  localparam int FRAME_W  = VA_W - OFFS_W,
  localparam int ENT_W    = 8 * ENT_BYTES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [PID_W-1:0] req_pid,
  input  logic [VA_W-1:0]  table_base,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [VA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_data,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic             rsp_fault_inner,
  output logic [VA_W-1:0]  rsp_paddr,
  output logic             rsp_writable,
  output logic             rsp_referenced,
  output logic             rsp_modified,
  output logic [VA_W-1:0]  rsp_vaddr,
  output logic [PID_W-1:0] rsp_pid
);
  walk_state_e      st;
  logic             accept, outer_ok, outer_bad, inner_ok, inner_bad;
  logic [VA_W-1:0]  calc_va, outer_addr, inner_addr;
  logic [VA_W-1:0]  va_q, mem_addr_q, paddr_q;
  logic [PID_W-1:0] pid_q;
  logic             flt_q, flt_inner_q, wr_q, ref_q, mod_q;
  logic [FRAME_W-1:0] ent_frame;
  pte_flags_t       ent_flags;

  // The outer address is formed from the live request while idle
  assign calc_va = (st == ST_IDLE) ? req_vaddr : va_q;

  ptw_entry_decode #(.ENT_W(ENT_W), .OFFS_W(OFFS_W)) u_dec (
    .entry (mem_rsp_data),
    .frame (ent_frame),
    .flags (ent_flags)
  );

  ptw_addr_calc #(.IDX_W(IDX_W), .OFFS_W(OFFS_W), .ENT_BYTES(ENT_BYTES)) u_calc (
    .vaddr       (calc_va),
    .table_base  (table_base),
    .outer_frame (ent_frame),
    .outer_addr  (outer_addr),
    .inner_addr  (inner_addr)
  );

  ptw_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .entry_valid   (ent_flags.valid),
    .state         (st),
    .accept        (accept),
    .outer_ok      (outer_ok),
    .outer_bad     (outer_bad),
    .inner_ok      (inner_ok),
    .inner_bad     (inner_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      va_q        <= '0;
      pid_q       <= '0;
      mem_addr_q  <= '0;
      paddr_q     <= '0;
      flt_q       <= 1'b0;
      flt_inner_q <= 1'b0;
      wr_q        <= 1'b0;
      ref_q       <= 1'b0;
      mod_q       <= 1'b0;
    end else begin
      if (accept) begin
        va_q        <= req_vaddr;
        pid_q       <= req_pid;
        mem_addr_q  <= outer_addr;
        paddr_q     <= '0;
        flt_q       <= 1'b0;
        flt_inner_q <= 1'b0;
        wr_q        <= 1'b0;
        ref_q       <= 1'b0;
        mod_q       <= 1'b0;
      end
      if (outer_ok) mem_addr_q <= inner_addr;
      if (outer_bad) begin
        flt_q       <= 1'b1;
        flt_inner_q <= 1'b0;
      end
      if (inner_bad) begin
        flt_q       <= 1'b1;
        flt_inner_q <= 1'b1;
      end
      if (inner_ok) begin
        paddr_q <= {ent_frame, va_q[OFFS_W-1:0]};
        wr_q    <= ent_flags.writable;
        ref_q   <= ent_flags.referenced;
        mod_q   <= ent_flags.modified;
      end
    end
  end

  assign req_ready       = (st == ST_IDLE);
  assign mem_req_valid   = (st == ST_RD_OUTER) || (st == ST_RD_INNER);
  assign mem_req_addr    = mem_addr_q;
  assign rsp_valid       = (st == ST_DONE) || (st == ST_FAULT);
  assign rsp_fault       = flt_q;
  assign rsp_fault_inner = flt_inner_q;
  assign rsp_paddr       = paddr_q;
  assign rsp_writable    = wr_q;
  assign rsp_referenced  = ref_q;
  assign rsp_modified    = mod_q;
  assign rsp_vaddr       = va_q;
  assign rsp_pid         = pid_q;

  // ---------------- assertions ----------------
  logic       rst_q;
  logic [1:0] rd_cnt;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst || (req_valid && req_ready)) rd_cnt <= '0;
    else if (mem_req_valid && mem_req_ready && rd_cnt != 2'd3) rd_cnt <= rd_cnt + 2'd1;
  end

  // R12: first cycle after reset is idle and quiet
  always @(posedge clk) begin
    if (rst_q === 1'b1 && rst === 1'b0) begin
      a_r12_reset_idle: assert (req_ready && !mem_req_valid && !rsp_valid);
    end
  end

  // R9: a read is never followed by another read request in the next cycle
  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  // R9: a stalled read holds its address
  a_r9_hold_addr: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R10: single response pulse, then idle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> (!rsp_valid && req_ready));

  // R8: taking a request makes the walker busy
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R5: an outer fault used exactly one read
  a_r5_outer_fault_one_read: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault && !rsp_fault_inner) |-> rd_cnt == 2'd1);

  // R3: a successful walk used two reads and keeps the page offset
  a_r3_offset_kept: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |->
      (rd_cnt == 2'd2 && rsp_paddr[OFFS_W-1:0] == rsp_vaddr[OFFS_W-1:0]));

endmodule

// File: tb/sim_pt_walker2.sv
module sim_pt_walker2;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 2;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [7:0]  req_pid = '0;
  logic [31:0] table_base = BASE;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        rsp_valid, rsp_fault, rsp_fault_inner;
  logic [31:0] rsp_paddr, rsp_vaddr;
  logic        rsp_writable, rsp_referenced, rsp_modified;
  logic [7:0]  rsp_pid;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker2 u0 (.*);

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] mem [0:4095];

  typedef struct packed {
    logic [31:0] va;
    logic [7:0]  pid;
    logic        flt;
    logic        inner;
    logic [31:0] pa;
    logic [2:0]  wrm;
    logic [1:0]  nrd;
  } vec_t;

  localparam vec_t VECS [0:8] = '{
    '{32'h0000_0123, 8'h11, 1'b0, 1'b0, 32'hABCD_E123, 3'b000, 2'd2},
    '{32'h003F_FFFF, 8'h22, 1'b0, 1'b0, 32'h1234_5FFF, 3'b111, 2'd2},
    '{32'hFFFF_F000, 8'h33, 1'b0, 1'b0, 32'hFFFF_F000, 3'b010, 2'd2},
    '{32'hFFE0_0040, 8'h44, 1'b0, 1'b0, 32'h0001_0040, 3'b101, 2'd2},
    '{32'h0140_0ABC, 8'h55, 1'b1, 1'b0, 32'h0,         3'b000, 2'd1},
    '{32'h0000_3010, 8'h66, 1'b1, 1'b1, 32'h0,         3'b000, 2'd2},
    '{32'h0080_0000, 8'h77, 1'b1, 1'b0, 32'h0,         3'b000, 2'd1},
    '{32'h01C0_9777, 8'h88, 1'b0, 1'b0, 32'h0BEE_F777, 3'b000, 2'd2},
    '{32'hFFC0_0555, 8'h99, 1'b1, 1'b1, 32'h0,         3'b000, 2'd2}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drives one walk, serves memory reads from the model, captures the result
  task automatic walk(input logic [31:0] va, input logic [7:0] pid, input int stall,
                      input bit junk, output logic g_flt, output logic g_inn,
                      output logic [31:0] g_pa, output logic [2:0] g_wrm,
                      output logic [31:0] g_va, output logic [7:0] g_pid,
                      output int nrd, output logic [31:0] a0, output logic [31:0] a1);
    int cnt;
    int wt;
    bit busy;
    bit seen;
    logic [31:0] held;
    nrd = 0; cnt = 0; wt = 0; busy = 0; seen = 0; held = '0;
    a0 = '0; a1 = '0; g_flt = 0; g_inn = 0; g_pa = '0; g_wrm = '0; g_va = '0; g_pid = '0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_pid = pid;
    @(negedge clk);
    if (junk) begin
      req_vaddr = ~va; req_pid = ~pid;
    end else req_valid = 1'b0;
    for (int i = 0; i < 80 && !seen; i++) begin
      mem_rsp_valid = 1'b0;
      mem_req_ready = 1'b0;
      if (rsp_valid) begin
        seen = 1; req_valid = 1'b0;
        g_flt = rsp_fault; g_inn = rsp_fault_inner; g_pa = rsp_paddr;
        g_wrm = {rsp_writable, rsp_referenced, rsp_modified};
        g_va = rsp_vaddr; g_pid = rsp_pid;
      end else if (busy) begin
        if (cnt > 0) cnt--;
        if (cnt == 0) begin
          mem_rsp_valid = 1'b1; mem_rsp_data = held; busy = 0;
        end
      end else if (mem_req_valid) begin
        if (wt < stall) wt++;
        else begin
          mem_req_ready = 1'b1;
          held = mem[mem_req_addr[13:2]];
          if (nrd == 0) a0 = mem_req_addr; else a1 = mem_req_addr;
          nrd++; busy = 1; cnt = LAT; wt = 0;
        end
      end
      if (!seen) @(negedge clk);
    end
    if (!seen) check("R10 response missing", 64'd0, 64'd1);
  endtask

  task automatic run_vec(input vec_t v, input int stall, input bit junk);
    logic f, fi; logic [31:0] pa, gva, a0, a1, e0, e1; logic [2:0] wrm; logic [7:0] gp; int nrd;
    walk(v.va, v.pid, stall, junk, f, fi, pa, wrm, gva, gp, nrd, a0, a1);
    e0 = BASE + {20'd0, v.va[31:22], 2'b00};
    e1 = {mem[e0[13:2]][31:12], 12'h000} + {20'd0, v.va[21:12], 2'b00};
    check("R1 outer read address", a0, e0);
    if (v.nrd == 2'd2) check("R2 inner read address", a1, e1);
    check(v.flt ? (v.inner ? "R6 inner fault" : "R5 outer fault") : "R3 no fault", f, v.flt);
    if (v.flt) check(v.inner ? "R6 fault level" : "R5 fault level", fi, v.inner);
    check("R5 read count", nrd, v.nrd);
    if (!v.flt) begin
      check("R3 physical address", pa, v.pa);
      check("R4 flags w/r/m", wrm, v.wrm);
    end
    check("R7 vaddr echo", gva, v.va);
    check("R7 pid echo", gp, v.pid);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    mem[12'h400] = 32'h0000_2001;  // outer 0 -> frame 2
    mem[12'h7FF] = 32'h0000_3001;  // outer 1023 -> frame 3
    mem[12'h405] = 32'h0000_2000;  // outer 5 invalid
    mem[12'h407] = 32'h0000_2001;  // outer 7 -> frame 2
    mem[12'h800] = 32'hABCD_E001;
    mem[12'hBFF] = 32'h1234_5063;
    mem[12'h803] = 32'h5555_5002;  // invalid but writable
    mem[12'h809] = 32'h0BEE_F001;
    mem[12'hFFF] = 32'hFFFF_F021;
    mem[12'hE00] = 32'h0001_0043;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 reset ready", req_ready, 1'b1);
    check("R12 reset no mem request", mem_req_valid, 1'b0);
    check("R12 reset no response", rsp_valid, 1'b0);

    for (int k = 0; k < 9; k++) run_vec(VECS[k], 0, 1'b0);

    // R9: memory stalls the read handshake
    run_vec(VECS[1], 3, 1'b0);
    run_vec(VECS[5], 2, 1'b0);

    // R8: a different request held high during the walk is not taken
    run_vec(VECS[3], 1, 1'b1);
    @(negedge clk);
    check("R8 back to idle", req_ready, 1'b1);
    check("R8 junk not taken", mem_req_valid, 1'b0);
    check("R10 no second pulse", rsp_valid, 1'b0);

    // R11: stray memory responses while idle
    for (int i = 0; i < 3; i++) begin
      mem_rsp_valid = 1'b1; mem_rsp_data = 32'hFFFF_FFFF;
      @(negedge clk);
      check("R11 idle ignores response", {req_ready, rsp_valid, mem_req_valid}, 3'b100);
    end
    mem_rsp_valid = 1'b0;
    run_vec(VECS[0], 0, 1'b0);

    // R12: reset in the middle of a walk
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = VECS[2].va; req_pid = 8'h5A;
    @(negedge clk);
    req_valid = 1'b0;
    check("R12 walk started", mem_req_valid, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 mid-walk reset idle", {req_ready, mem_req_valid, rsp_valid}, 3'b100);
    run_vec(VECS[7], 0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule